// File: doc/BRIEF.md
# Interleaved Sequential Read Controller

This block serves a stream of read requests from a set of low-order interleaved memory banks, with eight banks by default. The low address bits pick the bank, so consecutive addresses land in consecutive banks. Every bank needs a fixed number of cycles to finish a read. When a request is accepted, the target bank copies the address into its own register and starts its read. The shared address path is then free on the very next cycle for a request to another bank. Reads to different banks therefore overlap, and a sequential stream moves at one word per cycle once the pipeline has filled.

The controller keeps a slot pipeline that is as deep as the bank latency. Each accepted request enters it with its address, so the controller knows in advance which bank will drive the shared return bus in each cycle and takes the word in that cycle. Returned words wait in a small response queue and leave over a valid/ready interface, in acceptance order, each with its address. Requests are held back with a ready signal when the target bank is still reading or when the queue has no room reserved for another word. The bank contents are a fixed function of the address, so results can be predicted outside the block.

Top module: `interleaved_read_ctrl`

## Requirements
- R1: The bank of address A is A modulo 2^BANK_W, taken from the low BANK_W address bits. Two requests whose addresses differ in the low bits can be accepted on back-to-back cycles. A request to the bank of the previous request waits for that bank to finish.
- R2: The word stored at address A is ((A × 40503) mod 65536) XOR 0x5A5A. Every response carries exactly that word for the address it returns.
- R3: Responses leave in the same order as their requests were accepted, one response per accepted request, each with the request's address.
- R4: If the response queue is empty and rsp_ready is high, a response appears exactly LAT clock edges after the edge that accepted its request.
- R5: A bank accepts a new address no sooner than LAT edges after its previous one. While the bank is busy, req_ready is low for any address that maps to it.
- R6: When LAT ≤ 2^BANK_W, FIFO_D ≥ LAT+2 and rsp_ready stays high, a stream of consecutive addresses, including one that wraps past the top of the address space, is accepted on every cycle and returned on every cycle.
- R7: At most FIFO_D requests are accepted and not yet delivered. At that limit req_ready is low.
- R8: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_addr and rsp_data hold their values into the next cycle.
- R9: After a synchronous active-high reset, rsp_valid is low and req_ready is high for any address.
- R10: At most one bank drives the shared return bus in any cycle, and it is the bank the slot pipeline expects in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A read request is present |
| req_ready | output | 1 | The request can be taken on this edge |
| req_addr | input | 12 | Word address to read |
| rsp_valid | output | 1 | A returned word is present |
| rsp_ready | input | 1 | The consumer takes the word on this edge |
| rsp_addr | output | 12 | Address of the returned word |
| rsp_data | output | 16 | Returned word |

## Verification
The bench builds the block with eight banks, a latency of 5 and a response queue of 7 entries. With these values the queue limit, the same-bank waits and the full-rate condition are all reached within a few dozen cycles. Because the latency is odd and not a power of two, mistakes in countdowns and slot depths cannot cancel out against the bank count. A wrapping sequential run, same-bank and mixed-bank chains with exact acceptance spacings, a stalled consumer that fills the queue, and a long random run with request gaps and random back-pressure together cover the ordering and hold behaviour.

// File: rtl/il_pkg.sv
package il_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // One slot of the return schedule: a request whose data is due
    typedef struct packed {
        logic  vld;
        addr_t addr;
    } slot_t;

    // One returned word waiting for the consumer
    typedef struct packed {
        addr_t addr;
        data_t data;
    } rsp_t;

    // Fixed bank contents: a multiplicative hash of the address
    function automatic data_t word_of(addr_t a);
        return DATA_W'(32'(a) * 32'd40503) ^ DATA_W'(16'h5A5A);
    endfunction

endpackage

// File: rtl/il_bank.sv
module il_bank
    import il_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  addr_t addr,
    output logic  busy,
    output logic  ret,
    output data_t ret_data
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;
    addr_t         addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cap) begin
            cnt_q <= CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (cap) addr_q <= addr;
    end

    // In the final cycle of a read the bank drives the bus and can take a new address
    assign busy     = (cnt_q > CW'(1));
    assign ret      = (cnt_q == CW'(1));
    assign ret_data = ret ? word_of(addr_q) : '0;

endmodule

// File: rtl/il_tracker.sv
module il_tracker
    import il_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  addr_t push_addr,
    output slot_t due
);
    slot_t st_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) st_q[i] <= '0;
        end else begin
            st_q[0] <= '{vld: push, addr: push_addr};
            for (int i = 1; i < LAT; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign due = st_q[LAT-1];

endmodule

// File: rtl/il_fifo.sv
module il_fifo
    import il_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  rsp_t din,
    input  logic pop,
    output logic vld,
    output rsp_t dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rsp_t          mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    assign vld  = (cnt_q != '0);
    assign dout = mem[rd_q];

endmodule

// File: rtl/interleaved_read_ctrl.sv
module interleaved_read_ctrl
    import il_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int LAT    = 4,
    parameter int FIFO_D = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int NB  = 1 << BANK_W;
    localparam int CRW = $clog2(FIFO_D + 1);

    logic [BANK_W-1:0] req_bank;
    logic              issue;
    logic              pop;
    logic [NB-1:0]     bank_busy;
    logic [NB-1:0]     bank_ret;
    data_t             bank_rdata [NB];
    data_t             bus_data;
    slot_t             due;
    logic              due_vld;
    logic [BANK_W-1:0] due_bank;
    logic [CRW-1:0]    cred_q;
    rsp_t              fifo_out;

    assign req_bank  = req_addr[BANK_W-1:0];
    assign req_ready = !bank_busy[req_bank] && (cred_q < CRW'(FIFO_D));
    assign issue     = req_valid && req_ready;
    assign pop       = rsp_valid && rsp_ready;

    // Each accepted request reserves one response queue entry until it is delivered
    always_ff @(posedge clk) begin
        if (rst) cred_q <= '0;
        else     cred_q <= cred_q + CRW'(issue) - CRW'(pop);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        il_bank #(.LAT(LAT)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .cap      (issue && (req_bank == BANK_W'(b))),
            .addr     (req_addr),
            .busy     (bank_busy[b]),
            .ret      (bank_ret[b]),
            .ret_data (bank_rdata[b])
        );
    end

    // Shared return bus: idle banks drive zero
    always_comb begin
        bus_data = '0;
        for (int b = 0; b < NB; b++) bus_data = bus_data | bank_rdata[b];
    end

    il_tracker #(.LAT(LAT)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .push      (issue),
        .push_addr (req_addr),
        .due       (due)
    );

    assign due_vld  = due.vld;
    assign due_bank = due.addr[BANK_W-1:0];

    il_fifo #(.DEPTH(FIFO_D)) u_q (
        .clk  (clk),
        .rst  (rst),
        .push (due_vld),
        .din  ('{addr: due.addr, data: bus_data}),
        .pop  (pop),
        .vld  (rsp_valid),
        .dout (fifo_out)
    );

    assign rsp_addr = fifo_out.addr;
    assign rsp_data = fifo_out.data;

endmodule

// File: rtl/il_chk.sv
module il_chk
    import il_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int LAT    = 4,
    parameter int FIFO_D = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic [ADDR_W-1:0]   rsp_addr,
    input logic [DATA_W-1:0]   rsp_data,
    input logic [(1<<BANK_W)-1:0] bank_ret,
    input logic                due_vld,
    input logic [BANK_W-1:0]   due_bank
);
    localparam int NB = 1 << BANK_W;
    localparam int LW = $clog2(LAT + 1);
    localparam int OW = $clog2(FIFO_D + 2);

    logic          acc, dlv, rst_d;
    logic [OW-1:0] outst_q;
    logic [LW-1:0] gap_q [NB];

    assign acc = req_valid && req_ready;
    assign dlv = rsp_valid && rsp_ready;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) outst_q <= '0;
        else     outst_q <= outst_q + OW'(acc) - OW'(dlv);
        for (int b = 0; b < NB; b++) begin
            if (rst)                                     gap_q[b] <= '0;
            else if (acc && req_addr[BANK_W-1:0] == BANK_W'(b)) gap_q[b] <= LW'(LAT - 1);
            else if (gap_q[b] != '0)                     gap_q[b] <= gap_q[b] - 1'b1;
        end
    end

    // R9: the cycle after reset shows no response and an open request port
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            p_reset_r9: assert (!rsp_valid && req_ready);
        end
    end

    p_one_driver_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_ret));

    p_due_match_r10: assert property (@(posedge clk) disable iff (rst)
        due_vld |-> bank_ret[due_bank]);

    p_no_stray_r10: assert property (@(posedge clk) disable iff (rst)
        (bank_ret != '0) |-> due_vld);

    p_word_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_data == word_of(rsp_addr)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_data)));

    p_credit_cap_r7: assert property (@(posedge clk) disable iff (rst)
        outst_q <= OW'(FIFO_D));

    p_credit_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (outst_q == OW'(FIFO_D)) |-> !req_ready);

    for (genvar b = 0; b < NB; b++) begin : g_gap
        p_bank_gap_r5: assert property (@(posedge clk) disable iff (rst)
            (acc && req_addr[BANK_W-1:0] == BANK_W'(b)) |-> (gap_q[b] == '0));
    end

endmodule

bind interleaved_read_ctrl il_chk #(.BANK_W(BANK_W), .LAT(LAT), .FIFO_D(FIFO_D)) u_chk (.*);

// File: tb/tb_interleaved_read_ctrl.sv
module tb_interleaved_read_ctrl;

    localparam int CLK_P  = 10;
    localparam int BANK_W = 3;
    localparam int LAT    = 5;
    localparam int FIFO_D = 7;
    localparam int NB     = 1 << BANK_W;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, rsp_valid, rsp_ready;
    logic [11:0] req_addr, rsp_addr;
    logic [15:0] rsp_data;

    always #(CLK_P/2) clk = ~clk;

    interleaved_read_ctrl #(.BANK_W(BANK_W), .LAT(LAT), .FIFO_D(FIFO_D)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    int n_cmp = 0, n_bad = 0;
    int n_req, idx, exp_wr, exp_rd, step, hold_steps, acc_at_hold, wd_hit;
    int first_rsp_step, last_rsp_step;
    logic [11:0] req_list [0:255];
    logic [11:0] exp_addr [0:255];
    int          acc_step [0:255];

    function automatic logic [15:0] ref_word(logic [11:0] a);
        int unsigned p;
        p = int'(a) * 40503;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // rdy_mode: 0 always ready, 1 random, 2 low for hold_steps then high
    task automatic run_stream(int rdy_mode, bit gaps);
        bit          prev_hold = 0;
        logic [11:0] prev_a = '0;
        logic [15:0] prev_d = '0;
        idx = 0; exp_wr = 0; exp_rd = 0; step = 0; acc_at_hold = -1;
        first_rsp_step = -1; last_rsp_step = -1;
        while (idx < n_req || exp_rd < n_req) begin
            @(negedge clk);
            req_valid = (idx < n_req) && (!gaps || ($urandom % 4 != 0));
            req_addr  = req_valid ? req_list[idx] : 12'($urandom);
            case (rdy_mode)
                0:       rsp_ready = 1'b1;
                1:       rsp_ready = ($urandom % 3 != 0);
                default: rsp_ready = (step >= hold_steps);
            endcase
            #1;
            if (rdy_mode == 2 && step == hold_steps) acc_at_hold = exp_wr;
            if (prev_hold) begin
                chk(rsp_valid && rsp_addr == prev_a && rsp_data == prev_d,
                    "R8 hold", {rsp_valid, rsp_addr}, {1'b1, prev_a});
            end
            prev_hold = rsp_valid && !rsp_ready;
            prev_a = rsp_addr; prev_d = rsp_data;
            if (rsp_valid && rsp_ready) begin
                chk(rsp_addr == exp_addr[exp_rd], "R3 order", rsp_addr, exp_addr[exp_rd]);
                chk(rsp_data == ref_word(exp_addr[exp_rd]), "R2 data", rsp_data, ref_word(exp_addr[exp_rd]));
                if (exp_rd == 0) first_rsp_step = step;
                last_rsp_step = step;
                exp_rd++;
            end
            if (req_valid && req_ready) begin
                exp_addr[exp_wr] = req_addr;
                acc_step[exp_wr] = step;
                exp_wr++;
                idx++;
            end
            step++;
            if (step > 5000) begin
                chk(0, "watchdog", step, 5000);
                wd_hit = 1;
                break;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20250));
        wd_hit = 0;
        hold_steps = 0;
        rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        req_addr = 12'h5A3;
        #1;
        chk(!rsp_valid, "R9 rsp_valid", rsp_valid, 0);
        chk(req_ready, "R9 req_ready", req_ready, 1);

        // Sequential stream at full rate
        n_req = 64;
        for (int i = 0; i < 64; i++) req_list[i] = 12'(12'h100 + i);
        run_stream(0, 0);
        chk(acc_step[63] - acc_step[0] == 63, "R6 accept rate", acc_step[63] - acc_step[0], 63);
        chk(first_rsp_step - acc_step[0] == LAT + 1, "R4 latency", first_rsp_step - acc_step[0], LAT + 1);
        chk(last_rsp_step - first_rsp_step == 63, "R6 return rate", last_rsp_step - first_rsp_step, 63);

        // Same bank chain: spacing equals the bank latency
        n_req = 6;
        for (int i = 0; i < 6; i++) req_list[i] = 12'(3 + NB * i);
        run_stream(0, 0);
        for (int i = 1; i < 6; i++)
            chk(acc_step[i] - acc_step[i-1] == LAT, "R5 same bank gap", acc_step[i] - acc_step[i-1], LAT);

        // Mixed banks: 0x013,0x023 share bank 3; 0x024,0x01C share bank 4
        n_req = 4;
        req_list[0] = 12'h013; req_list[1] = 12'h023; req_list[2] = 12'h024; req_list[3] = 12'h01C;
        run_stream(0, 0);
        chk(acc_step[1] - acc_step[0] == LAT, "R1 same bank waits", acc_step[1] - acc_step[0], LAT);
        chk(acc_step[2] - acc_step[1] == 1, "R1 other bank next cycle", acc_step[2] - acc_step[1], 1);
        chk(acc_step[3] - acc_step[2] == LAT, "R1 low bits pick bank", acc_step[3] - acc_step[2], LAT);

        // Wrap past the top of the address space
        n_req = 10;
        for (int i = 0; i < 10; i++) req_list[i] = 12'(12'hFFB + i);
        run_stream(0, 0);
        chk(acc_step[9] - acc_step[0] == 9, "R6 wrap rate", acc_step[9] - acc_step[0], 9);

        // Consumer stalled: accepts stop at the queue size
        n_req = 12;
        for (int i = 0; i < 12; i++) req_list[i] = 12'(12'h040 + i);
        hold_steps = 30;
        run_stream(2, 0);
        chk(acc_at_hold == FIFO_D, "R7 credit limit", acc_at_hold, FIFO_D);

        // Random addresses, request gaps and random back-pressure
        n_req = 200;
        for (int i = 0; i < 200; i++)
            req_list[i] = (i % 5 == 0) ? 12'(($urandom % 64) * NB + 2) : 12'($urandom);
        run_stream(1, 1);
        chk(exp_rd == n_req, "R3 count", exp_rd, n_req);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule